// File: doc/BRIEF.md
# NAND Bad Block Table Scanner

After reset this block walks every erase block of a serial NAND device once, in ascending order, and builds a one-bit-per-block table of bad blocks together with a count of them. It does not drive the serial bus itself. It issues three kinds of requests through a valid/ready command port to a page sequencer: load a page into the device cache, read the status byte, and read a run of bytes from the cache. The sequencer returns status and data bytes on a single byte-wide response channel.

For each block the scanner loads the first page, polls status until the busy bit clears, and then reads a 16-byte spare header from a fixed column past the main data area. A block is bad if the leading factory marker byte is anything other than 0xFF, or if four header bytes hold a 32-bit signature written earlier by software. When every block has been classified, a done flag rises. From then on a query port returns the bad bit of any block, and a mark port can add blocks to the table. A device that stays busy for too long stops the scan and raises an error flag instead.

Top module: `bbt_scanner`

## Requirements
- R1: During reset and in the first cycle after it, `scan_done`, `scan_error` and `bad_count` are 0 and `cmd_valid` is low.
- R2: Blocks are visited in ascending order 0 to NUM_BLOCKS-1. Each visit starts with a page-load command: `cmd_op` = 0x13, `cmd_row` = block index shifted left by 6 (64 pages per block), `cmd_col` = 0, `cmd_len` = 0.
- R3: Each page load is followed by status commands (`cmd_op` = 0x0F, `cmd_col` = 0xC0, `cmd_row` = 0, `cmd_len` = 1), each answered by one response byte. A new status command is issued for as long as bit 0 of the returned byte is 1. The other bits of the status byte have no effect.
- R4: After a status byte with bit 0 = 0, one read command is issued (`cmd_op` = 0x03, `cmd_col` = 0x0800, `cmd_row` = 0, `cmd_len` = 16). It consumes exactly 16 response bytes, numbered 0 to 15 in arrival order. Cycles without `rsp_valid` between bytes are waited out.
- R5: A block whose spare byte 0 differs from 0xFF is bad, whatever the other bytes hold.
- R6: A block whose byte 0 equals 0xFF is bad exactly when bytes 8 to 11, with byte 8 as least significant, form 0xDEADBEEF (bytes EF, BE, AD, DE in that order). Any other pattern, including the reversed byte order, leaves the block good.
- R7: `bad_count` equals the number of distinct blocks set in the table. It never decreases and rises by at most 1 per cycle.
- R8: Once the last block is classified, `scan_done` rises and stays high until reset, and no further command is issued.
- R9: `qry_bad` reflects the table bit of `qry_blk` one cycle after `qry_blk` is presented, and it reads 0 whenever `scan_done` was low in that cycle.
- R10: With `scan_done` high, a one-cycle `mark_valid` on a good block sets its bit and raises `bad_count` by 1.
- R11: A mark on a block that is already bad leaves both the bit and `bad_count` unchanged.
- R12: A mark presented while `scan_done` is low is ignored.
- R13: If POLL_LIMIT consecutive status bytes all have bit 0 set, the scan stops. `scan_error` rises and stays high, `scan_done` stays low, and no further command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | output | 1 | A command to the page sequencer is offered |
| cmd_ready | input | 1 | Sequencer accepts the offered command this cycle |
| cmd_op | output | 8 | Command opcode (0x13 load, 0x0F status, 0x03 read) |
| cmd_row | output | 16 | Page row address for a load |
| cmd_col | output | 16 | Column for a read, feature address for a status |
| cmd_len | output | 8 | Number of response bytes expected |
| rsp_valid | input | 1 | Response byte present |
| rsp_data | input | 8 | Response byte (status or spare data) |
| scan_done | output | 1 | The whole device has been classified |
| scan_error | output | 1 | The scan stopped on a device that stayed busy |
| bad_count | output | 11 | Number of blocks in the table |
| qry_blk | input | 10 | Block index to look up |
| qry_bad | output | 1 | Table bit of the block presented on the previous cycle |
| mark_valid | input | 1 | Request to add a block to the table |
| mark_blk | input | 10 | Block index to add |

## Verification
A wrong internal state shows up mostly in the command stream, and quickly. A block counter that skips or repeats produces a load row on the very next page-load command. A poll counter that is off by one changes the number of status commands sent to a stuck device. A byte index that drifts makes the read end early or late, so the following load appears in the wrong place. A misclassified block is visible only later, once `scan_done` is high: as a wrong `qry_bad` bit and a `bad_count` off by one. For that reason the whole table is read back and compared block by block after the scan.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    localparam int ROW_W = 16;
    localparam int COL_W = 16;
    localparam int LEN_W = 8;
    localparam int BUSY_BIT = 0;
    localparam logic [7:0] STATUS_FEATURE_ADDR = 8'hC0;
    localparam logic [7:0] MARKER_CLEAN = 8'hFF;

    typedef enum logic [7:0] {
        OP_PAGE_LOAD  = 8'h13,
        OP_GET_STATUS = 8'h0F,
        OP_CACHE_READ = 8'h03
    } flash_op_e;

    typedef struct packed {
        flash_op_e          op;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [LEN_W-1:0]   len;
    } flash_cmd_t;

    typedef enum logic [2:0] {
        ST_START,
        ST_LOAD,
        ST_POLL,
        ST_POLL_WAIT,
        ST_READ,
        ST_RECV,
        ST_DECIDE,
        ST_HALT
    } scan_state_e;

    typedef struct packed {
        logic factory_hit;
        logic signature_hit;
    } verdict_t;

    function automatic logic [ROW_W-1:0] first_row(input logic [31:0] blk, input int shift);
        logic [31:0] wide;
        wide = blk << shift;
        return wide[ROW_W-1:0];
    endfunction

endpackage

// File: rtl/bbt_walker.sv
module bbt_walker
    import bbt_pkg::*;
#(
    parameter int          NUM_BLOCKS  = 1024,
    parameter int          PAGE_SHIFT  = 6,
    parameter int          POLL_LIMIT  = 100,
    parameter logic [15:0] SPARE_COL   = 16'h0800,
    parameter int          SPARE_BYTES = 16,
    localparam int         BLK_W       = $clog2(NUM_BLOCKS),
    localparam int         IDX_W       = $clog2(SPARE_BYTES),
    localparam int         POLL_W      = $clog2(POLL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             cmd_valid,
    output flash_cmd_t       cmd,
    input  logic             cmd_ready,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    output logic             byte_valid,
    output logic [IDX_W-1:0] byte_idx,
    output logic             decide,
    output logic [BLK_W-1:0] cur_blk,
    output logic             scan_done,
    output logic             scan_error
);

    localparam logic [BLK_W-1:0]  LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(SPARE_BYTES - 1);
    localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(POLL_LIMIT - 1);

    scan_state_e       state;
    logic [BLK_W-1:0]  blk;
    logic [IDX_W-1:0]  idx;
    logic [POLL_W-1:0] polls;
    logic              faulted;

    always_comb begin
        cmd       = '{op: OP_PAGE_LOAD, row: '0, col: '0, len: '0};
        cmd_valid = 1'b0;
        unique case (state)
            ST_LOAD: begin
                cmd_valid = 1'b1;
                cmd.op    = OP_PAGE_LOAD;
                cmd.row   = first_row(32'(blk), PAGE_SHIFT);
            end
            ST_POLL: begin
                cmd_valid = 1'b1;
                cmd.op    = OP_GET_STATUS;
                cmd.col   = COL_W'(STATUS_FEATURE_ADDR);
                cmd.len   = LEN_W'(1);
            end
            ST_READ: begin
                cmd_valid = 1'b1;
                cmd.op    = OP_CACHE_READ;
                cmd.col   = SPARE_COL;
                cmd.len   = LEN_W'(SPARE_BYTES);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_START;
            blk     <= '0;
            idx     <= '0;
            polls   <= '0;
            faulted <= 1'b0;
        end else begin
            unique case (state)
                ST_START: state <= ST_LOAD;
                ST_LOAD: if (cmd_ready) begin
                    state <= ST_POLL;
                    polls <= '0;
                end
                ST_POLL: if (cmd_ready) state <= ST_POLL_WAIT;
                ST_POLL_WAIT: if (rsp_valid) begin
                    if (!rsp_data[BUSY_BIT]) begin
                        state <= ST_READ;
                    end else if (polls == LAST_POLL) begin
                        state   <= ST_HALT;
                        faulted <= 1'b1;
                    end else begin
                        polls <= polls + 1'b1;
                        state <= ST_POLL;
                    end
                end
                ST_READ: if (cmd_ready) begin
                    state <= ST_RECV;
                    idx   <= '0;
                end
                ST_RECV: if (rsp_valid) begin
                    if (idx == LAST_IDX) state <= ST_DECIDE;
                    else                 idx   <= idx + 1'b1;
                end
                ST_DECIDE: begin
                    if (blk == LAST_BLK) begin
                        state <= ST_HALT;
                    end else begin
                        blk   <= blk + 1'b1;
                        state <= ST_LOAD;
                    end
                end
                ST_HALT: ;
                default: state <= ST_HALT;
            endcase
        end
    end

    assign byte_valid = (state == ST_RECV) && rsp_valid;
    assign byte_idx   = idx;
    assign decide     = (state == ST_DECIDE);
    assign cur_blk    = blk;
    assign scan_done  = (state == ST_HALT) && !faulted;
    assign scan_error = (state == ST_HALT) && faulted;

endmodule

// File: rtl/bbt_spare_check.sv
module bbt_spare_check
    import bbt_pkg::*;
#(
    parameter int          SPARE_BYTES = 16,
    parameter int          MARK_POS    = 0,
    parameter int          SIG_POS     = 8,
    parameter logic [31:0] SIGNATURE   = 32'hDEADBEEF,
    localparam int         IDX_W       = $clog2(SPARE_BYTES),
    localparam int         SIG_BYTES   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_data,
    output verdict_t         verdict,
    output logic             blk_bad
);

    logic [7:0]             mark_byte;
    logic [8*SIG_BYTES-1:0] sig_word;

    always_ff @(posedge clk) begin
        if (rst)                                             mark_byte <= MARKER_CLEAN;
        else if (byte_valid && byte_idx == IDX_W'(MARK_POS)) mark_byte <= byte_data;
    end

    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
        always_ff @(posedge clk) begin
            if (rst)
                sig_word[8*g +: 8] <= '0;
            else if (byte_valid && byte_idx == IDX_W'(SIG_POS + g))
                sig_word[8*g +: 8] <= byte_data;
        end
    end

    assign verdict.factory_hit   = (mark_byte != MARKER_CLEAN);
    assign verdict.signature_hit = !verdict.factory_hit && (sig_word == SIGNATURE);
    assign blk_bad               = verdict.factory_hit || verdict.signature_hit;

endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
    parameter int  NUM_BLOCKS = 1024,
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_set,
    input  logic [BLK_W-1:0] scan_blk,
    input  logic             mark_req,
    input  logic [BLK_W-1:0] mark_blk,
    input  logic             table_ready,
    input  logic [BLK_W-1:0] qry_blk,
    output logic             qry_bad,
    output logic [CNT_W-1:0] bad_count
);

    logic [NUM_BLOCKS-1:0] table_bits;
    logic [BLK_W-1:0]      set_blk;
    logic                  set_req;
    logic                  set_ok;
    logic                  qry_ok;

    assign set_req = scan_set || (mark_req && table_ready);
    assign set_blk = scan_set ? scan_blk : mark_blk;
    assign set_ok  = 32'(set_blk) < NUM_BLOCKS;
    assign qry_ok  = 32'(qry_blk) < NUM_BLOCKS;

    always_ff @(posedge clk) begin
        if (rst) begin
            table_bits <= '0;
            bad_count  <= '0;
            qry_bad    <= 1'b0;
        end else begin
            if (set_req && set_ok && !table_bits[set_blk]) begin
                table_bits[set_blk] <= 1'b1;
                bad_count           <= bad_count + 1'b1;
            end
            qry_bad <= table_ready && qry_ok && table_bits[qry_blk];
        end
    end

endmodule

// File: rtl/bbt_scanner.sv
module bbt_scanner
    import bbt_pkg::*;
#(
    parameter int          NUM_BLOCKS  = 1024,
    parameter int          PAGE_SHIFT  = 6,
    parameter int          POLL_LIMIT  = 100,
    parameter logic [15:0] SPARE_COL   = 16'h0800,
    parameter int          SPARE_BYTES = 16,
    parameter int          MARK_POS    = 0,
    parameter int          SIG_POS     = 8,
    parameter logic [31:0] SIGNATURE   = 32'hDEADBEEF
) (
    input  logic                              clk,
    input  logic                              rst,
    output logic                              cmd_valid,
    input  logic                              cmd_ready,
    output logic [7:0]                        cmd_op,
    output logic [15:0]                       cmd_row,
    output logic [15:0]                       cmd_col,
    output logic [7:0]                        cmd_len,
    input  logic                              rsp_valid,
    input  logic [7:0]                        rsp_data,
    output logic                              scan_done,
    output logic                              scan_error,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]   bad_count,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     qry_blk,
    output logic                              qry_bad,
    input  logic                              mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     mark_blk
);

    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int IDX_W = $clog2(SPARE_BYTES);

    flash_cmd_t       cmd;
    logic             byte_valid;
    logic [IDX_W-1:0] byte_idx;
    logic             decide;
    logic [BLK_W-1:0] cur_blk;
    logic             blk_bad;
    verdict_t         verdict;

    bbt_walker #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .POLL_LIMIT  (POLL_LIMIT),
        .SPARE_COL   (SPARE_COL),
        .SPARE_BYTES (SPARE_BYTES)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .cmd_ready  (cmd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .byte_valid (byte_valid),
        .byte_idx   (byte_idx),
        .decide     (decide),
        .cur_blk    (cur_blk),
        .scan_done  (scan_done),
        .scan_error (scan_error)
    );

    bbt_spare_check #(
        .SPARE_BYTES (SPARE_BYTES),
        .MARK_POS    (MARK_POS),
        .SIG_POS     (SIG_POS),
        .SIGNATURE   (SIGNATURE)
    ) u_check (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_idx   (byte_idx),
        .byte_data  (rsp_data),
        .verdict    (verdict),
        .blk_bad    (blk_bad)
    );

    bbt_bitmap #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .scan_set    (decide && blk_bad),
        .scan_blk    (cur_blk),
        .mark_req    (mark_valid),
        .mark_blk    (mark_blk),
        .table_ready (scan_done),
        .qry_blk     (qry_blk),
        .qry_bad     (qry_bad),
        .bad_count   (bad_count)
    );

    assign cmd_op  = cmd.op;
    assign cmd_row = cmd.row;
    assign cmd_col = cmd.col;
    assign cmd_len = cmd.len;

endmodule

// File: rtl/bbt_scanner_checks.sv
module bbt_scanner_checks #(
    parameter int          NUM_BLOCKS  = 1024,
    parameter int          PAGE_SHIFT  = 6,
    parameter logic [15:0] SPARE_COL   = 16'h0800,
    parameter int          SPARE_BYTES = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cmd_valid,
    input logic                            cmd_ready,
    input logic [7:0]                      cmd_op,
    input logic [15:0]                     cmd_row,
    input logic [15:0]                     cmd_col,
    input logic [7:0]                      cmd_len,
    input logic                            scan_done,
    input logic                            scan_error,
    input logic [$clog2(NUM_BLOCKS+1)-1:0] bad_count,
    input logic                            qry_bad
);

    a_r2_load_row_aligned: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h13) |-> (cmd_row[PAGE_SHIFT-1:0] == '0));

    a_r2_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_row) && $stable(cmd_col)));

    a_r4_read_shape: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h03) |-> (cmd_col == SPARE_COL && cmd_len == 8'(SPARE_BYTES)));

    a_r7_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bad_count >= $past(bad_count) && bad_count - $past(bad_count) <= 1));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(bad_count) <= NUM_BLOCKS);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !cmd_valid);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> scan_done);

    a_r9_query_gated: assert property (@(posedge clk) disable iff (rst)
        !scan_done |=> !qry_bad);

    a_r13_error_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(scan_done && scan_error));

    a_r13_error_sticky: assert property (@(posedge clk) disable iff (rst)
        scan_error |=> (scan_error && !cmd_valid));

endmodule

bind bbt_scanner bbt_scanner_checks #(
    .NUM_BLOCKS  (NUM_BLOCKS),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .SPARE_COL   (SPARE_COL),
    .SPARE_BYTES (SPARE_BYTES)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .cmd_len    (cmd_len),
    .scan_done  (scan_done),
    .scan_error (scan_error),
    .bad_count  (bad_count),
    .qry_bad    (qry_bad)
);

// File: tb/bbt_scanner_test.sv
module bbt_scanner_test;

    localparam int NB   = 1024;
    localparam int PLIM = 100;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] row;
        logic [15:0] col;
        logic [7:0]  len;
    } exp_cmd_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_op;
    logic [15:0] cmd_row;
    logic [15:0] cmd_col;
    logic [7:0]  cmd_len;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        scan_done;
    logic        scan_error;
    logic [10:0] bad_count;
    logic [9:0]  qry_blk = '0;
    logic        qry_bad;
    logic        mark_valid = 1'b0;
    logic [9:0]  mark_blk = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int stuck_blk = -1;
    exp_cmd_t exp_q[$];
    logic [7:0] rq[$];

    always #2 clk = ~clk;

    bbt_scanner uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_len(cmd_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .scan_done(scan_done), .scan_error(scan_error), .bad_count(bad_count),
        .qry_blk(qry_blk), .qry_bad(qry_bad),
        .mark_valid(mark_valid), .mark_blk(mark_blk)
    );

    function automatic bit factory_bad(int b);
        return (b == 0) || (b % 97 == 3);
    endfunction

    function automatic bit sig_bad(int b);
        return (b == NB - 1) || (b % 53 == 7);
    endfunction

    function automatic bit exp_bad(int b);
        return factory_bad(b) || sig_bad(b);
    endfunction

    function automatic int busy_n(int b);
        return b % 4;
    endfunction

    function automatic logic [7:0] spare_byte(int b, int i);
        logic [31:0] w;
        if (i == 0) begin
            if (factory_bad(b)) return (b % 2 == 1) ? 8'hFE : 8'h00;
            return 8'hFF;
        end
        if (i >= 8 && i <= 11) begin
            if (sig_bad(b))   w = 32'hDEADBEEF;
            else if (b == 5)  w = 32'hEFBEADDE;
            else if (b == 6)  w = 32'hDEADBEEE;
            else              w = 32'hFFFFFFFF;
            return w[8*(i-8) +: 8];
        end
        return 8'(i * 17 + b);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: expected command stream for one block
    task automatic push_block(input int b, input bit stuck);
        exp_q.push_back('{8'h13, 16'(b << 6), 16'h0000, 8'd0});
        if (stuck) begin
            for (int k = 0; k < PLIM; k++) exp_q.push_back('{8'h0F, 16'h0000, 16'h00C0, 8'd1});
        end else begin
            for (int k = 0; k <= busy_n(b); k++) exp_q.push_back('{8'h0F, 16'h0000, 16'h00C0, 8'd1});
            exp_q.push_back('{8'h03, 16'h0000, 16'h0800, 8'd16});
        end
    endtask

    task automatic query(input int b, output logic v);
        @(negedge clk) qry_blk = 10'(b);
        @(negedge clk) v = qry_bad;
    endtask

    task automatic mark(input int b);
        @(negedge clk) begin mark_valid = 1'b1; mark_blk = 10'(b); end
        @(negedge clk) mark_valid = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int t;
        t = 0;
        while (!scan_done && !scan_error && t < limit) begin
            @(negedge clk);
            t++;
        end
        chk(t < limit, "R8", "scan finished in time", t, limit);
    endtask

    // monitor and sequencer model
    initial begin : responder
        int cur_busy;
        int cur_blk;
        cur_busy = 0;
        cur_blk = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rq.size() > 0 && (cyc % 5) != 2) begin
                rsp_valid = 1'b1;
                rsp_data  = rq.pop_front();
            end else begin
                rsp_valid = 1'b0;
                rsp_data  = 8'h00;
            end
            cmd_ready = (cyc % 3) != 1;
            if (!rst && cmd_valid && cmd_ready) begin
                exp_cmd_t got;
                exp_cmd_t e;
                string tag;
                got = '{cmd_op, cmd_row, cmd_col, cmd_len};
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8 unexpected command: actual %h expected none", got);
                end else begin
                    e = exp_q.pop_front();
                    tag = (e.op == 8'h13) ? "R2" : (e.op == 8'h0F) ? "R3" : "R4";
                    if (got != e) begin
                        n_bad++;
                        $display("FAIL %s command: actual %h expected %h", tag, got, e);
                    end
                end
                case (cmd_op)
                    8'h13: begin
                        cur_blk  = int'(cmd_row) >> 6;
                        cur_busy = (cur_blk == stuck_blk) ? 1000000 : busy_n(cur_blk);
                    end
                    8'h0F: begin
                        if (cur_busy > 0) begin
                            rq.push_back(8'h01);
                            cur_busy--;
                        end else begin
                            rq.push_back(8'hFE);
                        end
                    end
                    8'h03: for (int i = 0; i < 16; i++) rq.push_back(spare_byte(cur_blk, i));
                    default: ;
                endcase
            end
        end
    end

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic v;
        int exp_cnt;
        int cnt0;
        for (int b = 0; b < NB; b++) push_block(b, 1'b0);
        repeat (4) @(negedge clk);
        chk(!scan_done && !scan_error && bad_count == 0 && !cmd_valid, "R1", "state in reset",
            int'(bad_count), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(!scan_done && !scan_error && bad_count == 0, "R1", "state after reset", int'(bad_count), 0);

        repeat (3000) @(negedge clk);
        query(0, v);
        chk(v == 1'b0 && !scan_done, "R9", "query of bad block 0 during scan", int'(v), 0);
        mark(2);

        wait_end(60000);
        chk(scan_done && !scan_error, "R8", "scan_done high, no error", int'(scan_done), 1);
        chk(exp_q.size() == 0, "R8", "expected commands left over", exp_q.size(), 0);
        exp_cnt = 0;
        for (int b = 0; b < NB; b++) if (exp_bad(b)) exp_cnt++;
        chk(int'(bad_count) == exp_cnt, "R7", "bad_count after scan", int'(bad_count), exp_cnt);

        for (int b = 0; b < NB; b++) begin
            query(b, v);
            chk(v == exp_bad(b), factory_bad(b) ? "R5" : "R6", $sformatf("table bit of block %0d", b),
                int'(v), int'(exp_bad(b)));
        end
        query(5, v);
        chk(v == 1'b0, "R6", "reversed signature stays good", int'(v), 0);
        query(2, v);
        chk(v == 1'b0, "R12", "mark during scan ignored", int'(v), 0);

        cnt0 = int'(bad_count);
        mark(2);
        @(negedge clk);
        query(2, v);
        chk(v == 1'b1, "R10", "marked block reads bad", int'(v), 1);
        chk(int'(bad_count) == cnt0 + 1, "R10", "count after mark", int'(bad_count), cnt0 + 1);
        mark(0);
        mark(2);
        @(negedge clk);
        chk(int'(bad_count) == cnt0 + 1, "R11", "count after repeat marks", int'(bad_count), cnt0 + 1);
        query(0, v);
        chk(v == 1'b1, "R11", "already bad block stays bad", int'(v), 1);
        repeat (50) @(negedge clk);
        chk(scan_done && exp_q.size() == 0, "R8", "done stays high and quiet", int'(scan_done), 1);

        // second run: a device stuck busy on block 20
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rq.delete();
        exp_q.delete();
        stuck_blk = 20;
        for (int b = 0; b < 20; b++) push_block(b, 1'b0);
        push_block(20, 1'b1);
        @(negedge clk);
        chk(!scan_done && !scan_error && bad_count == 0, "R1", "state in second reset", int'(bad_count), 0);
        @(negedge clk) rst = 1'b0;
        wait_end(20000);
        repeat (50) @(negedge clk);
        chk(scan_error && !scan_done, "R13", "error raised, done low", int'(scan_error), 1);
        chk(exp_q.size() == 0, "R13", "status polls before abort left over", exp_q.size(), 0);
        exp_cnt = 0;
        for (int b = 0; b < 20; b++) if (exp_bad(b)) exp_cnt++;
        chk(int'(bad_count) == exp_cnt, "R13", "count at abort", int'(bad_count), exp_cnt);
        query(0, v);
        chk(v == 1'b0, "R9", "query after abort reads not bad", int'(v), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule